// File: doc/BRIEF.md
# Fast Ethernet PCS Transmit Encoder

This block turns a nibble-wide MAC transmit stream into the code-bit stream of a 100 Mb/s twisted-pair link. It runs on the code-bit clock: every fifth cycle it raises `nib_take` and samples `tx_en`, `tx_er` and `txd`. From that sample it picks one 5-bit code-group. Between frames the group is idle. A frame opens with the two start-delimiter groups and closes with the two end-delimiter groups. Every other nibble goes through the 4B5B table, or becomes the halt group when the MAC flags an error.

The two start groups stand in for the first preamble octet, so the frame keeps its octet count on the wire. The MAC sends its normal preamble nibbles, and the first two are replaced. Each group is sent MSB-first, one bit per cycle. The bit is XORed with a free-running 11-bit LFSR and then drives an MLT-3 state machine. The MLT-3 level is the line-side output.

Top module: `pcs100_tx_encoder`

## Requirements
- R1: While `rst` is high, `cg_out` is 5'b11111, `code_bit` is 1, `mlt_lvl` is 2'b00 and `nib_take` is 1. The LFSR holds its seed.
- R2: After reset, `nib_take` is high in the first cycle and then in every fifth cycle, and in no other cycle. The inputs are sampled on the clock edge that ends a `nib_take` cycle, and `cg_out` shows the chosen group from the next cycle on.
- R3: Outside a frame, a sample with `tx_en` low selects the idle group 5'b11111.
- R4: A sample with `tx_en` high outside a frame selects J (5'b11000). The next sample selects K (5'b10001) whatever `txd` and `tx_er` hold.
- R5: Inside a frame, a sample with `tx_en` high and `tx_er` low selects the 4B5B code of `txd`. The codes for nibbles 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101.
- R6: Inside a frame, a sample with `tx_en` and `tx_er` both high selects the halt group 5'b00100 instead of the data code.
- R7: Inside a frame, the first sample with `tx_en` low selects T (5'b01101). The next sample selects R (5'b00111), and the frame is then over.
- R8: `code_bit` carries the current group MSB first, one bit per cycle. Bit 4 of a newly loaded group appears in the cycle after the load.
- R9: `scr_bit` = `code_bit` XOR bit 10 of an 11-bit LFSR. Out of reset the LFSR shifts left on every cycle, and its new bit 0 is bit10 XOR bit8. At reset it is loaded with 11'h5A5.
- R10: The MLT-3 level steps through 0, +1, 0, -1 in that order. It advances on the clock edge after a cycle with `scr_bit` = 1 and holds after a cycle with `scr_bit` = 0. The encoding is 2'b00 = 0, 2'b01 = +1, 2'b11 = -1, and it starts at 0.
- R11: `tx_en` is ignored in the sample that selects R. If `tx_en` is high there, R is still sent and the next sample starts a new frame with J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-bit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | MAC transmit enable |
| tx_er | input | 1 | MAC transmit error |
| txd | input | 4 | MAC transmit nibble |
| nib_take | output | 1 | High in the cycle whose closing edge samples the MAC inputs |
| cg_out | output | 5 | Code-group currently being serialized |
| code_bit | output | 1 | Unscrambled serial code bit |
| scr_bit | output | 1 | Scrambled serial code bit |
| mlt_lvl | output | 2 | MLT-3 line level (00 = 0, 01 = +1, 11 = -1) |

## Verification
The hardest cases to reach are those where the inputs must be ignored at a precise group boundary. One is `tx_er` asserted in the K slot. Another is `tx_en` raised again in the R slot, which starts a back-to-back frame with no idle group between. The driver waits for `nib_take` and sets each input exactly at the sample it targets. A frame then carries the error on the second preamble nibble and the re-assertion on the R sample, and the next frame follows at once. The scrambler and MLT-3 outputs are checked every cycle against a bench model of the LFSR and the level cycle, both seeded from reset.

// File: rtl/pcs100_tx_pkg.sv
package pcs100_tx_pkg;

    localparam int NIB_W  = 4;
    localparam int CG_W   = 5;
    localparam int LFSR_W = 11;
    localparam int LFSR_TAP = 9;

    typedef logic [CG_W-1:0] cg_t;

    localparam cg_t CG_IDLE = 5'b11111;
    localparam cg_t CG_J    = 5'b11000;
    localparam cg_t CG_K    = 5'b10001;
    localparam cg_t CG_T    = 5'b01101;
    localparam cg_t CG_R    = 5'b00111;
    localparam cg_t CG_H    = 5'b00100;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SEND_K,
        FR_DATA,
        FR_SEND_R
    } fr_state_e;

    typedef enum logic [1:0] {
        LV_ZERO = 2'b00,
        LV_POS  = 2'b01,
        LV_NEG  = 2'b11
    } mlt_lvl_e;

    function automatic cg_t enc_4b5b(input logic [NIB_W-1:0] nib);
        cg_t g;
        case (nib)
            4'h0: g = 5'b11110;
            4'h1: g = 5'b01001;
            4'h2: g = 5'b10100;
            4'h3: g = 5'b10101;
            4'h4: g = 5'b01010;
            4'h5: g = 5'b01011;
            4'h6: g = 5'b01110;
            4'h7: g = 5'b01111;
            4'h8: g = 5'b10010;
            4'h9: g = 5'b10011;
            4'hA: g = 5'b10110;
            4'hB: g = 5'b10111;
            4'hC: g = 5'b11010;
            4'hD: g = 5'b11011;
            4'hE: g = 5'b11100;
            default: g = 5'b11101;
        endcase
        return g;
    endfunction

    function automatic mlt_lvl_e phase_level(input logic [1:0] ph);
        mlt_lvl_e l;
        case (ph)
            2'd1:    l = LV_POS;
            2'd3:    l = LV_NEG;
            default: l = LV_ZERO;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/pcs100_tx_framer.sv
module pcs100_tx_framer
    import pcs100_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] txd,
    output cg_t              grp_next
);
    fr_state_e st, st_nx;

    always_comb begin
        grp_next = CG_IDLE;
        st_nx    = st;
        case (st)
            FR_IDLE: begin
                if (tx_en) begin
                    grp_next = CG_J;
                    st_nx    = FR_SEND_K;
                end
            end
            FR_SEND_K: begin
                grp_next = CG_K;
                st_nx    = FR_DATA;
            end
            FR_DATA: begin
                if (!tx_en) begin
                    grp_next = CG_T;
                    st_nx    = FR_SEND_R;
                end else if (tx_er) begin
                    grp_next = CG_H;
                end else begin
                    grp_next = enc_4b5b(txd);
                end
            end
            default: begin
                grp_next = CG_R;
                st_nx    = FR_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= FR_IDLE;
        end else if (take) begin
            st <= st_nx;
        end
    end

endmodule

// File: rtl/pcs100_tx_serializer.sv
module pcs100_tx_serializer
    import pcs100_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cg_t  grp_in,
    output logic take,
    output cg_t  grp_cur,
    output logic code_bit
);
    localparam int CNT_W = $clog2(CG_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CG_W - 1);

    logic [CNT_W-1:0] cnt;
    cg_t              shreg;

    assign take     = (cnt == '0);
    assign code_bit = shreg[CG_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            shreg   <= CG_IDLE;
            grp_cur <= CG_IDLE;
        end else begin
            cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
            if (take) begin
                shreg   <= grp_in;
                grp_cur <= grp_in;
            end else begin
                shreg <= {shreg[CG_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/pcs100_tx_scrambler.sv
module pcs100_tx_scrambler #(
    parameter int          W    = 11,
    parameter int          TAP  = 9,
    parameter logic [W-1:0] SEED = 11'h5A5
) (
    input  logic clk,
    input  logic rst,
    input  logic in_bit,
    output logic out_bit
);
    logic [W-1:0] s;
    logic         fb;

    assign fb      = s[W-1] ^ s[TAP-1];
    assign out_bit = in_bit ^ s[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            s <= SEED;
        end else begin
            s <= {s[W-2:0], fb};
        end
    end

endmodule

// File: rtl/pcs100_tx_mlt3.sv
module pcs100_tx_mlt3
    import pcs100_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_bit,
    output logic [1:0] lvl
);
    logic [1:0] phase;

    assign lvl = phase_level(phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 2'd0;
        end else if (in_bit) begin
            phase <= phase + 2'd1;
        end
    end

endmodule

// File: rtl/pcs100_tx_encoder.sv
module pcs100_tx_encoder
    import pcs100_tx_pkg::*;
#(
    parameter logic [LFSR_W-1:0] LFSR_SEED = 11'h5A5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] txd,
    output logic             nib_take,
    output logic [CG_W-1:0]  cg_out,
    output logic             code_bit,
    output logic             scr_bit,
    output logic [1:0]       mlt_lvl
);
    cg_t grp_next;
    cg_t grp_cur;

    pcs100_tx_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .take     (nib_take),
        .tx_en    (tx_en),
        .tx_er    (tx_er),
        .txd      (txd),
        .grp_next (grp_next)
    );

    pcs100_tx_serializer u_ser (
        .clk      (clk),
        .rst      (rst),
        .grp_in   (grp_next),
        .take     (nib_take),
        .grp_cur  (grp_cur),
        .code_bit (code_bit)
    );

    assign cg_out = grp_cur;

    pcs100_tx_scrambler #(
        .W    (LFSR_W),
        .TAP  (LFSR_TAP),
        .SEED (LFSR_SEED)
    ) u_scr (
        .clk     (clk),
        .rst     (rst),
        .in_bit  (code_bit),
        .out_bit (scr_bit)
    );

    pcs100_tx_mlt3 u_mlt (
        .clk    (clk),
        .rst    (rst),
        .in_bit (scr_bit),
        .lvl    (mlt_lvl)
    );

endmodule

// File: rtl/pcs100_tx_checker.sv
module pcs100_tx_checker
    import pcs100_tx_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            tx_en,
    input logic            nib_take,
    input logic [CG_W-1:0] cg_out,
    input logic            code_bit,
    input logic            scr_bit,
    input logic [1:0]      mlt_lvl
);
    logic seen;
    logic take_q;
    cg_t  last_grp;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen     <= 1'b0;
            take_q   <= 1'b0;
            last_grp <= CG_IDLE;
        end else begin
            seen   <= 1'b1;
            take_q <= nib_take;
            if (take_q) begin
                last_grp <= cg_out;
            end
        end
    end

    a_r2_take_isolated: assert property (@(posedge clk) disable iff (rst)
        nib_take |=> !nib_take);

    a_r8_msb_first: assert property (@(posedge clk) disable iff (rst)
        take_q |-> code_bit == cg_out[CG_W-1]);

    // R3 and R4: after idle or R, the next group is J when tx_en was sampled high, idle otherwise
    a_r3_idle_or_start: assert property (@(posedge clk) disable iff (rst)
        (take_q && (last_grp == CG_IDLE || last_grp == CG_R))
            |-> cg_out == ($past(tx_en) ? CG_J : CG_IDLE));

    a_r4_k_after_j: assert property (@(posedge clk) disable iff (rst)
        (take_q && last_grp == CG_J) |-> cg_out == CG_K);

    a_r7_r_after_t: assert property (@(posedge clk) disable iff (rst)
        (take_q && last_grp == CG_T) |-> cg_out == CG_R);

    a_r10_legal_level: assert property (@(posedge clk) disable iff (rst)
        mlt_lvl != 2'b10);

    a_r10_step_on_one: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(scr_bit)) |-> mlt_lvl != $past(mlt_lvl));

    a_r10_hold_on_zero: assert property (@(posedge clk) disable iff (rst)
        (seen && !$past(scr_bit)) |-> $stable(mlt_lvl));

endmodule

bind pcs100_tx_encoder pcs100_tx_checker i_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .nib_take (nib_take),
    .cg_out   (cg_out),
    .code_bit (code_bit),
    .scr_bit  (scr_bit),
    .mlt_lvl  (mlt_lvl)
);

// File: tb/test_pcs100_tx_encoder.sv
`timescale 1ns/1ps
module test_pcs100_tx_encoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       nib_take;
    logic [4:0] cg_out;
    logic       code_bit;
    logic       scr_bit;
    logic [1:0] mlt_lvl;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    localparam logic [4:0]  G_IDLE = 5'b11111;
    localparam logic [4:0]  G_J    = 5'b11000;
    localparam logic [4:0]  G_K    = 5'b10001;
    localparam logic [4:0]  G_T    = 5'b01101;
    localparam logic [4:0]  G_R    = 5'b00111;
    localparam logic [4:0]  G_H    = 5'b00100;
    localparam logic [10:0] SEED   = 11'h5A5;

    logic [4:0] tbl [16];

    pcs100_tx_encoder i_pcs100_tx_encoder (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .tx_er    (tx_er),
        .txd      (txd),
        .nib_take (nib_take),
        .cg_out   (cg_out),
        .code_bit (code_bit),
        .scr_bit  (scr_bit),
        .mlt_lvl  (mlt_lvl)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    // scoreboard of expected groups
    logic [4:0] exp_q[$];
    string      tag_q[$];

    task automatic drive(input bit en, input bit er, input logic [3:0] d,
                         input logic [4:0] e, input string tag);
        while (!nib_take) @(negedge clk);
        tx_en = en;
        tx_er = er;
        txd   = d;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic send_frame(input int len, input int base, input int er_at,
                              input bit er_in_k, input bit en_in_r);
        drive(1'b1, 1'b0, 4'h5, G_J, "R4");
        drive(1'b1, er_in_k, 4'h5, G_K, "R4");
        for (int i = 0; i < 13; i++) drive(1'b1, 1'b0, 4'h5, tbl[5], "R5");
        drive(1'b1, 1'b0, 4'hD, tbl[13], "R5");
        for (int i = 0; i < len; i++) begin
            logic [3:0] n;
            n = 4'((base + i * 7) % 16);
            if (i == er_at) drive(1'b1, 1'b1, n, G_H, "R6");
            else            drive(1'b1, 1'b0, n, tbl[n], "R5");
        end
        drive(1'b0, 1'b0, 4'h0, G_T, "R7");
        drive(en_in_r, 1'b0, 4'h0, G_R, en_in_r ? "R11" : "R7");
    endtask

    // monitor with bench-side scrambler and MLT-3 model
    logic        rst_s;
    logic [10:0] m_lfsr;
    logic [1:0]  m_phase;
    logic [4:0]  m_grp;
    int          m_bidx;
    int          m_cyc;
    bit          m_ld;

    always @(posedge clk) rst_s <= rst;

    function automatic logic [1:0] lvl_of(input logic [1:0] ph);
        return (ph == 2'd1) ? 2'b01 : (ph == 2'd3) ? 2'b11 : 2'b00;
    endfunction

    always @(negedge clk) begin
        logic ebit, escr;
        if (rst_s !== 1'b0) begin
            m_lfsr  = SEED;
            m_phase = 2'd0;
            m_grp   = G_IDLE;
            m_bidx  = 4;
            m_cyc   = 0;
            m_ld    = 1'b0;
            chk(cg_out == G_IDLE, "R1", "reset cg_out", cg_out, G_IDLE);
            chk(mlt_lvl == 2'b00, "R1", "reset mlt_lvl", mlt_lvl, 0);
            chk(nib_take == 1'b1, "R1", "reset nib_take", nib_take, 1);
        end
        if (m_ld) begin
            logic [4:0] e;
            string      t;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
            end else begin
                e = G_IDLE;
                t = "R3";
            end
            chk(cg_out == e, t, "cg_out", cg_out, e);
            m_grp  = e;
            m_bidx = 0;
        end
        chk(nib_take == (m_cyc == 0), "R2", "nib_take", nib_take, m_cyc == 0);
        ebit = m_grp[4 - m_bidx];
        chk(code_bit == ebit, "R8", "code_bit", code_bit, ebit);
        escr = ebit ^ m_lfsr[10];
        chk(scr_bit == escr, "R9", "scr_bit", scr_bit, escr);
        chk(mlt_lvl == lvl_of(m_phase), "R10", "mlt_lvl", mlt_lvl, lvl_of(m_phase));
        // model the coming clock edge
        m_ld    = (m_cyc == 0);
        m_lfsr  = {m_lfsr[9:0], m_lfsr[10] ^ m_lfsr[8]};
        m_phase = m_phase + {1'b0, escr};
        if (m_bidx < 4) m_bidx++;
        m_cyc   = (m_cyc + 1) % 5;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 20000, 0);
        summary();
    end

    initial begin
        tbl[0]  = 5'b11110; tbl[1]  = 5'b01001; tbl[2]  = 5'b10100; tbl[3]  = 5'b10101;
        tbl[4]  = 5'b01010; tbl[5]  = 5'b01011; tbl[6]  = 5'b01110; tbl[7]  = 5'b01111;
        tbl[8]  = 5'b10010; tbl[9]  = 5'b10011; tbl[10] = 5'b10110; tbl[11] = 5'b10111;
        tbl[12] = 5'b11010; tbl[13] = 5'b11011; tbl[14] = 5'b11100; tbl[15] = 5'b11101;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R3: idle fill before any frame
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 4'(i), G_IDLE, "R3");
        // R5: every nibble value (step 7 covers all 16)
        send_frame(16, 0, -1, 1'b0, 1'b0);
        for (int i = 0; i < 2; i++) drive(1'b0, 1'b1, 4'hF, G_IDLE, "R3");
        // R6 halt on error, R4 error in K slot ignored, R11 tx_en in R slot ignored
        send_frame(8, 3, 3, 1'b1, 1'b1);
        // back-to-back frame right after R
        send_frame(5, 9, -1, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, 4'h0, G_IDLE, "R3");
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
        summary();
    end

endmodule